// File: doc/BRIEF.md
# Fruitless-Cycle Guard and Branch Index Selector

This block follows one pseudo-random walk through an additive iteration, one step at a time. Each step presents the tag of the point just reached and a base table index taken from that point's bits. The block remembers the most recent points of the walk. When a point repeats exactly within that window, the walk has fallen into a fruitless cycle. The block then raises a one-cycle flag and moves an escape offset to a new value.

The block returns the branch-table index for the step leaving the current point. That index is the base index plus the escape offset, wrapped to the table size. The offset is updated in the same cycle that a cycle is found, so the very step that would repeat the loop already takes a different branch. The escape rule never restarts the walk, so the walk stays deterministic. A strobe marks the start of a new walk and clears everything learned about the previous one.

Top module: `walk_cycle_guard`

## Requirements
- R1: After a synchronous reset the point history is empty and the offset is zero: the next step gives branch_idx = base_idx and cycle_hit = 0, even for a point seen before the reset.
- R2: On a step with no repeat, branch_idx = (base_idx + L) mod 1024, where L is the current escape offset, and cycle_hit = 0.
- R3: A step whose point_tag equals the tag of the point recorded k steps earlier (k from 1 to 10, the smallest such k) raises cycle_hit in that cycle.
- R4: On a hit, L becomes k if k > L, and otherwise becomes L + k (mod 1024). For example, a 2-cycle from L = 0 gives offset 2, and a second 2-cycle then gives 4. The branch_idx of that same step already uses the new L. L changes at no other time except R1 and R7.
- R5: A repeat at a distance of 11 steps or more is not detected: cycle_hit stays 0 and the offset is unchanged.
- R6: The index addition wraps modulo the 1024-entry table, so the index is 10 bits wide.
- R7: While new_walk is high, branch_idx = base_idx and cycle_hit = 0, and the history and L are cleared. If step_valid is also high, the presented point becomes the first entry of the new history.
- R8: With step_valid low, cycle_hit = 0 and neither the history nor L changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| new_walk | input | 1 | Start of a fresh walk; clears history and offset |
| step_valid | input | 1 | A point is presented this cycle |
| point_tag | input | 32 | Tag or coordinate of the current point |
| base_idx | input | 10 | Branch index derived from the point |
| branch_idx | output | 10 | Effective branch-table index for the next step |
| cycle_hit | output | 1 | High in a cycle where a repeat was found |

## Verification
The hardest condition to reach is a second cycle that is no longer than the offset already learned. This is the case where the offset must grow by addition rather than by taking a maximum. The scripted walk reaches it by building a 2-cycle, then a second 2-cycle, and later a 3-cycle on top of an offset of 4. Each of these runs through the exact step sequence needed. A 10-step repeat at the edge of the window and an 11-step repeat just beyond it are driven as separate walks. This shows that the window length is exactly ten.

// File: rtl/walk_cycle_guard.sv
module walk_cycle_guard #(
  parameter int TAG_W = 32,
  parameter int IDX_W = 10,
  parameter int DEPTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             new_walk,
  input  logic             step_valid,
  input  logic [TAG_W-1:0] point_tag,
  input  logic [IDX_W-1:0] base_idx,
  output logic [IDX_W-1:0] branch_idx,
  output logic             cycle_hit
);
  localparam int KW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] hist [1:DEPTH];
  logic [DEPTH:1]   hv;
  logic [IDX_W-1:0] ofs;
  logic [KW-1:0]    k;

  always_comb begin
    k = '0;
    for (int i = DEPTH; i >= 1; i--)
      if (hv[i] && hist[i] == point_tag) k = KW'(i);
  end

  wire             hit    = step_valid && !new_walk && (k != '0);
  wire [IDX_W-1:0] kx     = IDX_W'(k);
  wire [IDX_W-1:0] ofs_nx = !hit ? ofs : (kx > ofs) ? kx : ofs + kx;

  assign branch_idx = new_walk ? base_idx : base_idx + ofs_nx;
  assign cycle_hit  = hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hv  <= '0;
      ofs <= '0;
    end else if (new_walk) begin
      hv  <= DEPTH'(step_valid);
      ofs <= '0;
    end else if (step_valid) begin
      hv  <= {hv[DEPTH-1:1], 1'b1};
      ofs <= ofs_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (step_valid) begin
      hist[1] <= point_tag;
      for (int i = 2; i <= DEPTH; i++) hist[i] <= hist[i-1];
    end
  end
endmodule

// File: rtl/walk_cycle_guard_chk.sv
module walk_cycle_guard_chk #(
  parameter int TAG_W = 32,
  parameter int IDX_W = 10,
  parameter int DEPTH = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             new_walk,
  input logic             step_valid,
  input logic [TAG_W-1:0] point_tag,
  input logic [IDX_W-1:0] base_idx,
  input logic [IDX_W-1:0] branch_idx,
  input logic             cycle_hit
);
  logic [IDX_W-1:0] off;
  assign off = branch_idx - base_idx;

  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cycle_hit && off == '0));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !step_valid |-> !cycle_hit);

  p_new_walk_base_r7: assert property (@(posedge clk) disable iff (rst)
    new_walk |-> (branch_idx == base_idx && !cycle_hit));

  p_offset_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cycle_hit) && !$past(new_walk) && !cycle_hit && !new_walk)
      |-> $stable(off));
endmodule

bind walk_cycle_guard walk_cycle_guard_chk #(
  .TAG_W(TAG_W), .IDX_W(IDX_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .new_walk(new_walk), .step_valid(step_valid),
  .point_tag(point_tag), .base_idx(base_idx),
  .branch_idx(branch_idx), .cycle_hit(cycle_hit)
);

// File: tb/walk_cycle_guard_test.sv
module walk_cycle_guard_test;
  logic        clk = 0;
  logic        rst, new_walk, step_valid;
  logic [31:0] point_tag;
  logic [9:0]  base_idx;
  logic [9:0]  branch_idx;
  logic        cycle_hit;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  walk_cycle_guard uut (
    .clk(clk), .rst(rst), .new_walk(new_walk), .step_valid(step_valid),
    .point_tag(point_tag), .base_idx(base_idx),
    .branch_idx(branch_idx), .cycle_hit(cycle_hit)
  );

  typedef struct packed {
    logic        nw;
    logic        sv;
    logic [31:0] pt;
    logic [9:0]  base;
    logic [9:0]  idx;
    logic        hit;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 32'h11,   10'd5,   10'd5, 1'b0},
    '{1'b0, 1'b1, 32'h22,   10'd7,   10'd7, 1'b0},
    '{1'b0, 1'b0, 32'h22,   10'd8,   10'd8, 1'b0},
    '{1'b0, 1'b1, 32'h11,   10'd5,   10'd7, 1'b1},
    '{1'b0, 1'b1, 32'h33,   10'd9,  10'd11, 1'b0},
    '{1'b0, 1'b1, 32'h44,   10'd1,   10'd3, 1'b0},
    '{1'b0, 1'b1, 32'h33,   10'd9,  10'd13, 1'b1},
    '{1'b0, 1'b1, 32'h55, 10'd1020,  10'd0, 1'b0},
    '{1'b1, 1'b1, 32'h11,   10'd6,   10'd6, 1'b0},
    '{1'b0, 1'b1, 32'h22,   10'd2,   10'd2, 1'b0},
    '{1'b0, 1'b1, 32'h23,   10'd2,   10'd2, 1'b0},
    '{1'b0, 1'b1, 32'h24,   10'd2,   10'd2, 1'b0},
    '{1'b0, 1'b1, 32'h11,   10'd2,   10'd6, 1'b1},
    '{1'b0, 1'b1, 32'h25, 10'd1023,  10'd3, 1'b0},
    '{1'b0, 1'b1, 32'h24,   10'd0,   10'd7, 1'b1}
  };

  task automatic check(input string req, input logic [9:0] ei, input logic eh);
    checks++;
    if (branch_idx !== ei || cycle_hit !== eh) begin
      errors++;
      $display("FAIL %s: idx=%0d hit=%0b expected idx=%0d hit=%0b",
               req, branch_idx, cycle_hit, ei, eh);
    end
  endtask

  task automatic step(input logic nw, input logic sv, input logic [31:0] pt,
                      input logic [9:0] b, input string req,
                      input logic [9:0] ei, input logic eh);
    @(negedge clk);
    new_walk = nw; step_valid = sv; point_tag = pt; base_idx = b;
    #1 check(req, ei, eh);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; new_walk = 0; step_valid = 0; point_tag = 0; base_idx = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // scripted walk: R2, R3, R4 escalation, R6 wrap, R7, R8
    for (int i = 0; i < NV; i++)
      step(VEC[i].nw, VEC[i].sv, VEC[i].pt, VEC[i].base,
           "R2/R3/R4/R6/R7/R8 vector", VEC[i].idx, VEC[i].hit);

    // R1: reset clears offset and history
    step(1'b0, 1'b1, 32'h77, 10'd4, "R1 pre", 10'd11, 1'b0);
    @(negedge clk); rst = 1; step_valid = 0;
    @(negedge clk); rst = 0;
    step(1'b0, 1'b1, 32'h77, 10'd4, "R1", 10'd4, 1'b0);

    // R3: 10-step repeat at the edge of the window
    step(1'b1, 1'b1, 32'h100, 10'd50, "R7", 10'd50, 1'b0);
    for (int i = 1; i < 10; i++) step(1'b0, 1'b1, 32'h100 + i, 10'd50, "R2", 10'd50, 1'b0);
    step(1'b0, 1'b1, 32'h100, 10'd50, "R3 10-cycle", 10'd60, 1'b1);
    step(1'b0, 1'b1, 32'h200, 10'd50, "R4 holds", 10'd60, 1'b0);

    // R5: 11-step repeat is not detected
    step(1'b1, 1'b1, 32'h300, 10'd20, "R7", 10'd20, 1'b0);
    for (int i = 1; i < 11; i++) step(1'b0, 1'b1, 32'h300 + i, 10'd20, "R2", 10'd20, 1'b0);
    step(1'b0, 1'b1, 32'h300, 10'd20, "R5 11-distance", 10'd20, 1'b0);

    // R3: 1-step repeat, then R7 new_walk without a step
    step(1'b0, 1'b1, 32'h300, 10'd20, "R3 1-cycle", 10'd21, 1'b1);
    step(1'b1, 1'b0, 32'h300, 10'd20, "R7 no step", 10'd20, 1'b0);
    step(1'b0, 1'b1, 32'h300, 10'd20, "R7 cleared", 10'd20, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule